// File: doc/BRIEF.md
# Per-Lane High-Speed Timing Calculator

This block turns a lane bit rate, given in Mbps, into the set of transmit timing values that one lane of a MIPI D-PHY needs: the high-speed prepare, zero and trail periods, the exit period, the clock pre/post margins, the low-power period, the three bus-turnaround periods and the two wakeup counts. A controller places the rate and a lane-kind select (clock lane or data lane) on the inputs, pulses `start_i`, and later reads the values when `done_o` pulses. The values stay on the outputs until the next accepted request overwrites them.

The prepare, zero and trail values come from a table of rate bands. All other values are nanosecond or unit-interval durations converted to whole clock cycles with rounding up. Durations that belong to the high-speed side are counted in byte-clock cycles (lane rate / 8). The turnaround periods are counted in escape-clock cycles, where the escape clock is the byte clock divided by the smallest integer that brings it to 20 MHz or below. All of this arithmetic runs through one shared bit-serial divider, so a request takes a fixed number of cycles.

Top module: `hs_lane_timing_calc`

## Requirements
- R1: After reset every timing output and `done_o` are 0. `wake_hi_o` is always 3 and `wake_lo_o` is always 0xFF.
- R2: Band selection uses the band limits 110, 150, 200, 250, 300, 400, 500, 600, 700, 800 and 1000 Mbps. The block picks the lowest limit that is at or above the rate, and the 1000 band when the rate is above all of them. A rate of 0 is treated as 1.
- R3: `hs_prepare_o` and `hs_trail_o` take the band's shared values. `hs_zero_o` takes the band's clock-lane value when `lane_clk_i` is 1 and its data-lane value when it is 0. For example, at 110 Mbps the values are prepare 0x20, clock zero 0x16, data zero 0x02 and trail 0x22.
- R4: `hs_exit_o` = ceil(120 ns × byte clock), with byte clock = rate/8.
- R5: UI = round(1000/rate) ns, with halves rounded up. On the clock lane, `clk_pre_o` = ceil(8·UI ns × byte clock) and `clk_post_o` = ceil((70 + 52·UI) ns × byte clock). On a data lane both are 0.
- R6: Let n = ceil(60 ns × byte clock). `lpx_o` = n − 2 when n ≥ 2, and n otherwise.
- R7: Escape divider = ceil(byte clock / 20 MHz). Escape clock = floor(byte clock / divider), in Hz. `ta_go_o`, `ta_sure_o` and `ta_wait_o` = ceil(240, 120 and 300 ns × escape clock).
- R8: If `start_i` is sampled high at edge S while the block is idle, `done_o` is high for exactly one cycle, beginning at edge S + 10·(DIV_W+2) + 1. All fields are valid from one cycle before that edge.
- R9: A `start_i` that arrives while a request is in progress is ignored. While idle, the outputs hold their values.
- R10: Each value keeps only its low bits, by field: prepare 7, zero 6, trail 7, exit 5, clk_pre 4, clk_post 4, lpx 6, each turnaround field 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| lane_clk_i | input | 1 | 1 = clock lane, 0 = data lane |
| rate_mbps_i | input | RATE_W | Lane bit rate in Mbps |
| done_o | output | 1 | One-cycle completion pulse |
| hs_prepare_o | output | 7 | HS prepare count |
| hs_zero_o | output | 6 | HS zero count |
| hs_trail_o | output | 7 | HS trail count |
| hs_exit_o | output | 5 | HS exit count, byte clocks |
| clk_post_o | output | 4 | Clock post count, byte clocks |
| clk_pre_o | output | 4 | Clock pre count, byte clocks |
| lpx_o | output | 6 | Low-power period count, offset by 2 |
| ta_go_o | output | 6 | Turnaround go count, escape clocks |
| ta_sure_o | output | 6 | Turnaround sure count, escape clocks |
| ta_wait_o | output | 6 | Turnaround wait count, escape clocks |
| wake_hi_o | output | 2 | Wakeup high count, fixed |
| wake_lo_o | output | 8 | Wakeup low count, fixed |

## Verification
The bench targets these cases and the failure each one would expose:
- Rates exactly at a band limit and one above it. An off-by-one comparison shifts every band-derived field into the neighbouring band.
- Rates above the top limit, and rate 0. A missing clamp or missing zero guard leaves the band fields at zero or hangs the divider on a zero divisor.
- Slow rates, where the raw lpx is 1. A subtraction without the guard wraps lpx to 63.
- Fast rates, where clk_post overflows its 4 bits. Wrong truncation gives a different value there.
- Both lane kinds. Swapped zero entries or clock-only fields leaking onto data lanes show up directly.
- Starts issued mid-request and starts held high through completion. A design that accepts them restarts and misses the fixed done cycle.

// File: rtl/hs_timing_pkg.sv
package hs_timing_pkg;

  localparam int PREP_W  = 7;
  localparam int ZERO_W  = 6;
  localparam int TRAIL_W = 7;
  localparam int EXIT_W  = 5;
  localparam int CLKM_W  = 4;
  localparam int LPX_W   = 6;
  localparam int TA_W    = 6;

  localparam int NUM_BANDS = 11;
  localparam int NUM_STEPS = 10;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ISSUE,
    S_WAIT,
    S_DONE
  } calc_state_e;

  // Order of the divider jobs; later jobs consume results of earlier ones.
  typedef enum logic [3:0] {
    J_ESCDIV,
    J_UI,
    J_ESCCLK,
    J_EXIT,
    J_PRE,
    J_POST,
    J_LPX,
    J_TAGO,
    J_TASURE,
    J_TAWAIT
  } job_e;

  typedef struct packed {
    logic [PREP_W-1:0]  prep;
    logic [ZERO_W-1:0]  zero_clk;
    logic [ZERO_W-1:0]  zero_dat;
    logic [TRAIL_W-1:0] trail;
  } band_entry_t;

  function automatic int unsigned band_limit(input int idx);
    case (idx)
      0:       return 110;
      1:       return 150;
      2:       return 200;
      3:       return 250;
      4:       return 300;
      5:       return 400;
      6:       return 500;
      7:       return 600;
      8:       return 700;
      9:       return 800;
      default: return 1000;
    endcase
  endfunction

  function automatic band_entry_t band_values(input int idx);
    band_entry_t e;
    case (idx)
      0:       e = '{7'h20, 6'h16, 6'h02, 7'h22};
      1:       e = '{7'h06, 6'h16, 6'h03, 7'h45};
      2:       e = '{7'h18, 6'h17, 6'h04, 7'h0b};
      3:       e = '{7'h05, 6'h17, 6'h05, 7'h16};
      4:       e = '{7'h51, 6'h18, 6'h06, 7'h2c};
      5:       e = '{7'h64, 6'h19, 6'h07, 7'h33};
      6:       e = '{7'h20, 6'h1b, 6'h07, 7'h4e};
      7:       e = '{7'h6a, 6'h1d, 6'h08, 7'h3a};
      8:       e = '{7'h3e, 6'h1e, 6'h08, 7'h6a};
      9:       e = '{7'h21, 6'h1f, 6'h09, 7'h29};
      default: e = '{7'h09, 6'h20, 6'h09, 7'h27};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/hs_band_lut.sv
module hs_band_lut
  import hs_timing_pkg::*;
#(
  parameter int RATE_W = 11
) (
  input  logic [RATE_W-1:0] rate_i,
  output band_entry_t       entry_o
);

  logic [NUM_BANDS-1:0] fits;

  // One comparator per band limit.
  for (genvar g = 0; g < NUM_BANDS; g++) begin : g_limit
    assign fits[g] = (32'(rate_i) <= band_limit(g));
  end

  // Lowest fitting band wins; with no fit the top band is used (clamp).
  always_comb begin
    int pick;
    pick = NUM_BANDS - 1;
    for (int i = NUM_BANDS - 1; i >= 0; i--) begin
      if (fits[i]) pick = i;
    end
    entry_o = band_values(pick);
  end

endmodule

// File: rtl/hs_serial_div.sv
module hs_serial_div #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         fin_o,
  output logic [W-1:0] quo_o
);

  localparam int CW = $clog2(W + 1);

  logic         busy_q, busy_d;
  logic         fin_q, fin_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W:0]   rem_q, rem_d;
  logic [W-1:0] quo_q, quo_d;
  logic [W-1:0] den_q, den_d;
  logic [W:0]   rem_sh;
  logic         take;

  always_comb begin
    rem_sh = {rem_q[W-1:0], quo_q[W-1]};
    take   = (rem_sh >= {1'b0, den_q});
    busy_d = busy_q;
    fin_d  = 1'b0;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    den_d  = den_q;
    if (go_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      rem_d  = '0;
      quo_d  = num_i;
      den_d  = den_i;
    end else if (busy_q) begin
      rem_d = take ? (rem_sh - {1'b0, den_q}) : rem_sh;
      quo_d = {quo_q[W-2:0], take};
      cnt_d = cnt_q + CW'(1);
      if (cnt_q == CW'(W - 1)) begin
        busy_d = 1'b0;
        fin_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
    end else begin
      busy_q <= busy_d;
      fin_q  <= fin_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      den_q  <= den_d;
    end
  end

  assign fin_o = fin_q;
  assign quo_o = quo_q;

  // Every rounded-up conversion relies on a proper remainder at the end.
  assert_rem_below_den_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> (rem_q < {1'b0, den_q}));

endmodule

// File: rtl/hs_job_operands.sv
module hs_job_operands
  import hs_timing_pkg::*;
#(
  parameter int RATE_W = 11,
  parameter int W      = 40
) (
  input  job_e              job_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [W-1:0]      escdiv_i,
  input  logic [W-1:0]      ui_i,
  input  logic [W-1:0]      esc_i,
  output logic [W-1:0]      num_o,
  output logic [W-1:0]      den_o
);

  localparam logic [W-1:0] BYTE_NS = W'(8000);
  localparam logic [W-1:0] GIGA    = W'(1000000000);

  logic [W-1:0] r;

  assign r = W'(rate_i);

  // Rate in Mbps: byte clock in Hz is r*125000; cycles for t ns = t*r/8000.
  always_comb begin
    num_o = '0;
    den_o = W'(1);
    case (job_i)
      J_ESCDIV: begin num_o = r + W'(159);                 den_o = W'(160);       end
      J_UI:     begin num_o = r + W'(2000);                den_o = r + r;         end
      J_ESCCLK: begin num_o = r * W'(125000);              den_o = escdiv_i;      end
      J_EXIT:   begin num_o = r * W'(120) + BYTE_NS - W'(1); den_o = BYTE_NS;     end
      J_PRE:    begin num_o = ui_i * r + W'(999);          den_o = W'(1000);      end
      J_POST:   begin num_o = (W'(70) + W'(52) * ui_i) * r + BYTE_NS - W'(1);
                      den_o = BYTE_NS; end
      J_LPX:    begin num_o = r * W'(60) + BYTE_NS - W'(1);  den_o = BYTE_NS;     end
      J_TAGO:   begin num_o = esc_i * W'(240) + GIGA - W'(1); den_o = GIGA;       end
      J_TASURE: begin num_o = esc_i * W'(120) + GIGA - W'(1); den_o = GIGA;       end
      J_TAWAIT: begin num_o = esc_i * W'(300) + GIGA - W'(1); den_o = GIGA;       end
      default:  begin num_o = '0;                          den_o = W'(1);         end
    endcase
  end

endmodule

// File: rtl/hs_lane_timing_calc.sv
module hs_lane_timing_calc
  import hs_timing_pkg::*;
#(
  parameter int RATE_W = 11,
  parameter int DIV_W  = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                lane_clk_i,
  input  logic [RATE_W-1:0]   rate_mbps_i,
  output logic                done_o,
  output logic [PREP_W-1:0]   hs_prepare_o,
  output logic [ZERO_W-1:0]   hs_zero_o,
  output logic [TRAIL_W-1:0]  hs_trail_o,
  output logic [EXIT_W-1:0]   hs_exit_o,
  output logic [CLKM_W-1:0]   clk_post_o,
  output logic [CLKM_W-1:0]   clk_pre_o,
  output logic [LPX_W-1:0]    lpx_o,
  output logic [TA_W-1:0]     ta_go_o,
  output logic [TA_W-1:0]     ta_sure_o,
  output logic [TA_W-1:0]     ta_wait_o,
  output logic [1:0]          wake_hi_o,
  output logic [7:0]          wake_lo_o
);

  localparam job_e LAST_JOB = job_e'(NUM_STEPS - 1);

  calc_state_e st_q, st_d;
  job_e        job_q, job_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic        lane_q, lane_d;
  logic [DIV_W-1:0] escdiv_q, escdiv_d, ui_q, ui_d, esc_q, esc_d;
  logic        done_q, done_d;

  logic [PREP_W-1:0]  prep_q, prep_d;
  logic [ZERO_W-1:0]  zero_q, zero_d;
  logic [TRAIL_W-1:0] trail_q, trail_d;
  logic [EXIT_W-1:0]  exit_q, exit_d;
  logic [CLKM_W-1:0]  post_q, post_d, pre_q, pre_d;
  logic [LPX_W-1:0]   lpx_q, lpx_d;
  logic [TA_W-1:0]    tago_q, tago_d, tasure_q, tasure_d, tawait_q, tawait_d;

  logic             div_go, div_fin;
  logic [DIV_W-1:0] div_num, div_den, div_quo;
  band_entry_t      band;

  hs_band_lut #(.RATE_W(RATE_W)) u_band (
    .rate_i  (rate_q),
    .entry_o (band)
  );

  hs_job_operands #(.RATE_W(RATE_W), .W(DIV_W)) u_ops (
    .job_i    (job_q),
    .rate_i   (rate_q),
    .escdiv_i (escdiv_q),
    .ui_i     (ui_q),
    .esc_i    (esc_q),
    .num_o    (div_num),
    .den_o    (div_den)
  );

  hs_serial_div #(.W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go_i  (div_go),
    .num_i (div_num),
    .den_i (div_den),
    .fin_o (div_fin),
    .quo_o (div_quo)
  );

  always_comb begin
    st_d     = st_q;
    job_d    = job_q;
    rate_d   = rate_q;
    lane_d   = lane_q;
    escdiv_d = escdiv_q;
    ui_d     = ui_q;
    esc_d    = esc_q;
    prep_d   = prep_q;
    zero_d   = zero_q;
    trail_d  = trail_q;
    exit_d   = exit_q;
    post_d   = post_q;
    pre_d    = pre_q;
    lpx_d    = lpx_q;
    tago_d   = tago_q;
    tasure_d = tasure_q;
    tawait_d = tawait_q;
    div_go   = 1'b0;
    done_d   = (st_q == S_DONE);
    case (st_q)
      S_IDLE: begin
        if (start_i) begin
          rate_d = (rate_mbps_i == '0) ? RATE_W'(1) : rate_mbps_i;
          lane_d = lane_clk_i;
          job_d  = J_ESCDIV;
          st_d   = S_ISSUE;
        end
      end
      S_ISSUE: begin
        div_go = 1'b1;
        st_d   = S_WAIT;
      end
      S_WAIT: begin
        if (div_fin) begin
          case (job_q)
            J_ESCDIV: escdiv_d = div_quo;
            J_UI:     ui_d     = div_quo;
            J_ESCCLK: esc_d    = div_quo;
            J_EXIT:   exit_d   = div_quo[EXIT_W-1:0];
            J_PRE:    pre_d    = lane_q ? div_quo[CLKM_W-1:0] : '0;
            J_POST:   post_d   = lane_q ? div_quo[CLKM_W-1:0] : '0;
            J_LPX:    lpx_d    = (div_quo >= DIV_W'(2)) ? (div_quo[LPX_W-1:0] - LPX_W'(2))
                                                        : div_quo[LPX_W-1:0];
            J_TAGO:   tago_d   = div_quo[TA_W-1:0];
            J_TASURE: tasure_d = div_quo[TA_W-1:0];
            J_TAWAIT: begin
              tawait_d = div_quo[TA_W-1:0];
              prep_d   = band.prep;
              zero_d   = lane_q ? band.zero_clk : band.zero_dat;
              trail_d  = band.trail;
            end
            default: ;
          endcase
          if (job_q == LAST_JOB) begin
            st_d = S_DONE;
          end else begin
            job_d = job_e'(job_q + 4'd1);
            st_d  = S_ISSUE;
          end
        end
      end
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      job_q    <= J_ESCDIV;
      rate_q   <= '0;
      lane_q   <= 1'b0;
      escdiv_q <= '0;
      ui_q     <= '0;
      esc_q    <= '0;
      done_q   <= 1'b0;
      prep_q   <= '0;
      zero_q   <= '0;
      trail_q  <= '0;
      exit_q   <= '0;
      post_q   <= '0;
      pre_q    <= '0;
      lpx_q    <= '0;
      tago_q   <= '0;
      tasure_q <= '0;
      tawait_q <= '0;
    end else begin
      st_q     <= st_d;
      job_q    <= job_d;
      rate_q   <= rate_d;
      lane_q   <= lane_d;
      escdiv_q <= escdiv_d;
      ui_q     <= ui_d;
      esc_q    <= esc_d;
      done_q   <= done_d;
      prep_q   <= prep_d;
      zero_q   <= zero_d;
      trail_q  <= trail_d;
      exit_q   <= exit_d;
      post_q   <= post_d;
      pre_q    <= pre_d;
      lpx_q    <= lpx_d;
      tago_q   <= tago_d;
      tasure_q <= tasure_d;
      tawait_q <= tawait_d;
    end
  end

  assign done_o       = done_q;
  assign hs_prepare_o = prep_q;
  assign hs_zero_o    = zero_q;
  assign hs_trail_o   = trail_q;
  assign hs_exit_o    = exit_q;
  assign clk_post_o   = post_q;
  assign clk_pre_o    = pre_q;
  assign lpx_o        = lpx_q;
  assign ta_go_o      = tago_q;
  assign ta_sure_o    = tasure_q;
  assign ta_wait_o    = tawait_q;
  assign wake_hi_o    = 2'd3;
  assign wake_lo_o    = 8'hFF;

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE) && start_i |=> $stable(rate_q) && $stable(lane_q));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE) |=> $stable({prep_q, zero_q, trail_q, exit_q, post_q, pre_q,
                                  lpx_q, tago_q, tasure_q, tawait_q}));

  assert_data_lane_clk_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !lane_q |-> (clk_post_o == '0) && (clk_pre_o == '0));

  assert_rate_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ISSUE) |-> (rate_q != '0));

endmodule

// File: tb/tb_hs_lane_timing_calc.sv
module tb_hs_lane_timing_calc;

  localparam int RATE_W = 11;
  localparam int DIV_W  = 40;
  localparam int LAT    = 10 * (DIV_W + 2) + 1;
  localparam longint GIGA = 64'd1000000000;

  logic clk, rst_n, start_i, lane_clk_i;
  logic [RATE_W-1:0] rate_mbps_i;
  logic done_o;
  logic [6:0] hs_prepare_o, hs_trail_o;
  logic [5:0] hs_zero_o, lpx_o, ta_go_o, ta_sure_o, ta_wait_o;
  logic [4:0] hs_exit_o;
  logic [3:0] clk_post_o, clk_pre_o;
  logic [1:0] wake_hi_o;
  logic [7:0] wake_lo_o;

  hs_lane_timing_calc #(.RATE_W(RATE_W), .DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .lane_clk_i(lane_clk_i),
    .rate_mbps_i(rate_mbps_i), .done_o(done_o),
    .hs_prepare_o(hs_prepare_o), .hs_zero_o(hs_zero_o), .hs_trail_o(hs_trail_o),
    .hs_exit_o(hs_exit_o), .clk_post_o(clk_post_o), .clk_pre_o(clk_pre_o),
    .lpx_o(lpx_o), .ta_go_o(ta_go_o), .ta_sure_o(ta_sure_o), .ta_wait_o(ta_wait_o),
    .wake_hi_o(wake_hi_o), .wake_lo_o(wake_lo_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  // Reference model state
  int m_cnt = 0;
  bit m_done = 0;
  int p_rate = 0;
  bit p_lane = 0;
  longint e_prep, e_zero, e_trail, e_exit, e_post, e_pre, e_lpx, e_tago, e_tasure, e_tawait;

  int lim   [11] = '{110, 150, 200, 250, 300, 400, 500, 600, 700, 800, 1000};
  int t_prep[11] = '{'h20, 'h06, 'h18, 'h05, 'h51, 'h64, 'h20, 'h6a, 'h3e, 'h21, 'h09};
  int t_zc  [11] = '{'h16, 'h16, 'h17, 'h17, 'h18, 'h19, 'h1b, 'h1d, 'h1e, 'h1f, 'h20};
  int t_zd  [11] = '{'h02, 'h03, 'h04, 'h05, 'h06, 'h07, 'h07, 'h08, 'h08, 'h09, 'h09};
  int t_trl [11] = '{'h22, 'h45, 'h0b, 'h16, 'h2c, 'h33, 'h4e, 'h3a, 'h6a, 'h29, 'h27};

  function automatic longint up_div(longint a, longint b);
    return (a + b - 1) / b;
  endfunction

  task automatic expect_fields(int rate, bit lane);
    longint r, bclk, ediv, esc, ui, raw;
    int band;
    r    = (rate == 0) ? 1 : rate;
    bclk = r * 1000000 / 8;
    ediv = up_div(bclk, 20000000);
    esc  = bclk / ediv;
    ui   = (GIGA + r * 500000) / (r * 1000000);
    band = 10;
    for (int i = 10; i >= 0; i--) if (r <= lim[i]) band = i;
    e_prep  = t_prep[band];
    e_zero  = lane ? t_zc[band] : t_zd[band];
    e_trail = t_trl[band];
    e_exit  = up_div(120 * bclk, GIGA) % 32;
    e_pre   = lane ? up_div(8 * ui * bclk, GIGA) % 16 : 0;
    e_post  = lane ? up_div((70 + 52 * ui) * bclk, GIGA) % 16 : 0;
    raw     = up_div(60 * bclk, GIGA);
    e_lpx   = ((raw >= 2) ? raw - 2 : raw) % 64;
    e_tago   = up_div(240 * esc, GIGA) % 64;
    e_tasure = up_div(120 * esc, GIGA) % 64;
    e_tawait = up_div(300 * esc, GIGA) % 64;
  endtask

  task automatic chk(longint act, longint exp, string tag);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d (rate=%0d lane_clk=%0d) t=%0t",
               tag, act, exp, p_rate, p_lane, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_done = 0;
      e_prep = 0; e_zero = 0; e_trail = 0; e_exit = 0; e_post = 0;
      e_pre = 0; e_lpx = 0; e_tago = 0; e_tasure = 0; e_tawait = 0;
    end else begin
      vectors++;
      chk(done_o, m_done, "R8 done pulse timing");
      chk(wake_hi_o, 3, "R1 wakeup high");
      chk(wake_lo_o, 255, "R1 wakeup low");
      if (m_cnt == 0) begin
        // R9: idle outputs hold; R1 reset values before the first request
        chk(hs_prepare_o, e_prep,  "R3 prepare");
        chk(hs_zero_o,    e_zero,  "R3 zero");
        chk(hs_trail_o,   e_trail, "R3 trail (R2 band)");
        chk(hs_exit_o,    e_exit,  "R4 exit");
        chk(clk_pre_o,    e_pre,   "R5 clk_pre");
        chk(clk_post_o,   e_post,  "R5 clk_post (R10 truncation)");
        chk(lpx_o,        e_lpx,   "R6 lpx");
        chk(ta_go_o,      e_tago,  "R7 ta_go");
        chk(ta_sure_o,    e_tasure,"R7 ta_sure");
        chk(ta_wait_o,    e_tawait,"R7 ta_wait");
      end
      // advance the model to the next rising edge
      m_done = 0;
      if (m_cnt == 0) begin
        if (start_i) begin
          m_cnt = LAT; p_rate = rate_mbps_i; p_lane = lane_clk_i;
        end
      end else begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_done = 1;
          expect_fields(p_rate, p_lane);
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic wait_idle();
    while (m_cnt != 0 || m_done) @(posedge clk);
  endtask

  task automatic run(int rate, bit lane);
    wait_idle();
    @(posedge clk); #1;
    start_i = 1'b1; rate_mbps_i = RATE_W'(rate); lane_clk_i = lane;
    @(posedge clk); #1;
    start_i = 1'b0;
    wait_idle();
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; lane_clk_i = 1'b0; rate_mbps_i = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R2 band edges, clamp and zero rate; R3 both lane kinds
    run(110, 1); run(110, 0); run(111, 1); run(150, 0); run(151, 1);
    run(200, 0); run(250, 1); run(300, 1); run(301, 0); run(400, 1);
    run(500, 0); run(600, 1); run(700, 0); run(800, 1); run(1000, 1);
    run(1001, 0); run(2047, 1); run(0, 1); run(80, 0);
    // R6 slow rates with lpx raw below 2; R10 fast rate overflowing clk_post
    run(1, 1); run(16, 0); run(2000, 1); run(1500, 1); run(161, 0); run(480, 1);

    // R9: start during a request is ignored
    wait_idle();
    @(posedge clk); #1;
    start_i = 1'b1; rate_mbps_i = RATE_W'(640); lane_clk_i = 1'b1;
    @(posedge clk); #1; start_i = 1'b0;
    repeat (60) @(posedge clk); #1;
    start_i = 1'b1; rate_mbps_i = RATE_W'(90); lane_clk_i = 1'b0;
    repeat (3) @(posedge clk); #1; start_i = 1'b0;
    wait_idle();

    // R8/R9: start held high across completion restarts right at done
    @(posedge clk); #1;
    start_i = 1'b1; rate_mbps_i = RATE_W'(333); lane_clk_i = 1'b0;
    while (!m_done) @(posedge clk);
    #1 rate_mbps_i = RATE_W'(950); lane_clk_i = 1'b1;
    @(posedge clk); #1; start_i = 1'b0;
    wait_idle();
    repeat (5) @(posedge clk);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule